// File: doc/BRIEF.md
# Packet Command Protocol Engine

This block is the device side of a packet command interface. A host reaches it through a small register port. The port holds byte-wide task-file registers and a 16-bit data register. The host starts a transfer by writing the packet opcode 0xA0 to the command register. It then sends a 12-byte command packet as six words. After that the host follows the device through a busy phase, an optional data-in phase and a completion phase. The status, phase code, byte count and error registers change at each step. An interrupt request line marks the points where the host must act.

Three packet commands are decoded:
- test-unit-ready (opcode 0x00);
- a query that returns a fixed 12-byte response (opcode 0x11);
- a sense request that returns the last error condition (opcode 0x03).

Every other packet opcode completes as unsupported, and so does every other task-file command. A unit-attention condition is armed by reset. It makes the first packet command after each reset fail, however late that command arrives.

Reads have no latency: `host_rdata` reflects `host_addr` in the same cycle. The side effects of a read take place at the clock edge that ends a cycle with `host_rd` high. Those side effects are clearing the interrupt and advancing the data pointer.

Top module: `atapi_pkt_engine`

## Requirements
- R1: After reset, status reads 0x50 and error, count, byte count low and byte count high read 0x00. `host_irq` is low. A data-register read outside the data-in phase returns 0xFFFF.
- R2: Writing 0xA0 to the command register (address 7) while idle enters the packet phase from the next cycle. In that phase status reads 0x58, count reads 0x01 and error reads 0x00. Host-loaded byte count registers keep their values, and `host_irq` stays low.
- R3: In the packet phase, six writes to the data register (address 0) form the packet, and the low byte of the first word is the opcode. The cycle after the sixth write shows status 0xD0, and the count value is unchanged.
- R4: Each busy phase lasts exactly BUSY_CYCLES cycles. `host_irq` rises at the edge that ends it.
- R5: Opcodes 0x03 and 0x11 enter the data-in phase. There status reads 0x58, count reads 0x02, byte count low (address 4) reads 0x0C and byte count high (address 5) reads 0x00. Each data-register read returns the next word, with the lower-numbered byte in bits 7:0.
- R6: For the query, response byte k is 0x40+3k. For the sense request, byte 0 is 0x70, byte 2 holds the sense key, byte 7 is 0x0A and byte 8 holds the additional sense code. All other sense bytes are 0x00.
- R7: After the sixth data read the device is busy, showing status 0xD0 with count 0x02. It then completes with status 0x50, count 0x03 and error 0x00, and `host_irq` goes high.
- R8: The first packet command after each reset completes with status 0x51, error 0x60 and count 0x03, and records sense key 6 with code 0x29. That clears the condition. Any successful completion clears the recorded sense. Test-unit-ready completes with status 0x50, error 0x00 and count 0x03.
- R9: An unsupported packet opcode completes with status 0x51, error 0x04 and count 0x03, and records sense key 5 with code 0x20. A command-register value other than 0xA0 written while idle completes at once with status 0x51, error 0x04 and `host_irq` high. That command leaves the unit-attention condition armed.
- R10: Reading status (address 7) clears `host_irq`. Reading alternate status (address 14) returns the same value and leaves `host_irq` unchanged.
- R11: Command-register writes are ignored unless the engine is idle. Task-file register writes are also ignored outside the idle state, so busy and data-in phases are undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register select: 0 data, 1 error/feature, 2 count, 3 sector, 4 byte count low, 5 byte count high, 6 device, 7 status/command, 14 alternate status |
| host_wr | input | 1 | Write strobe, one edge per write |
| host_rd | input | 1 | Read strobe; side effects act at the edge |
| host_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| host_rdata | output | 16 | Read data for host_addr, combinational |
| host_irq | output | 1 | Interrupt request |

## Verification
Most results are due one cycle after the edge that carries their stimulus. This covers a command acceptance, the sixth packet word, the sixth data read, a status read clearing the interrupt, and an immediate abort. The bench samples every output in the middle of the low clock phase that follows that edge. It never samples at an edge.

The end of a busy phase is due BUSY_CYCLES cycles after the edge that began it. The bench does not wait a fixed time for it. Instead it reads once per cycle and counts the samples that show 0xD0, and that count must equal BUSY_CYCLES exactly. Any reads or ignored writes made during the busy window are counted as busy samples too, so the timing stays exact.

// File: rtl/atapi_pkt_pkg.sv
// Package: shared phase encoding, register addresses, opcodes and the
// byte generators for the two data-in responses.
// Assumes: responses are 12 bytes, i.e. six 16-bit words.
package atapi_pkt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD  = 3'd1,
        PH_CBSY = 3'd2,
        PH_DIN  = 3'd3,
        PH_DBSY = 3'd4
    } phase_e;

    localparam logic [3:0] A_DATA = 4'd0;
    localparam logic [3:0] A_ERR  = 4'd1;
    localparam logic [3:0] A_CNT  = 4'd2;
    localparam logic [3:0] A_SECT = 4'd3;
    localparam logic [3:0] A_BCLO = 4'd4;
    localparam logic [3:0] A_BCHI = 4'd5;
    localparam logic [3:0] A_DEV  = 4'd6;
    localparam logic [3:0] A_STAT = 4'd7;
    localparam logic [3:0] A_ALT  = 4'd14;

    localparam logic [7:0] CMD_PACKET = 8'hA0;
    localparam logic [7:0] OP_READY   = 8'h00;
    localparam logic [7:0] OP_SENSE   = 8'h03;
    localparam logic [7:0] OP_QUERY   = 8'h11;

    localparam int PKT_WORDS  = 6;
    localparam int RESP_WORDS = 6;

    // Byte k of the fixed query response.
    function automatic logic [7:0] query_byte(input logic [7:0] k);
        return 8'h40 + k * 8'd3;
    endfunction

    // Byte k of the sense response built from the recorded condition.
    function automatic logic [7:0] sense_byte(input logic [7:0] k,
                                              input logic [3:0] key,
                                              input logic [7:0] asc);
        case (k)
            8'd0:    return 8'h70;
            8'd2:    return {4'h0, key};
            8'd7:    return 8'h0A;
            8'd8:    return asc;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/atapi_pkt_collect.sv
// Packet collector: counts the host words of a command packet and keeps the
// opcode (low byte of the first word).
// Assumes: push only arrives while the engine is in the packet phase.
module atapi_pkt_collect #(
    parameter int WORDS = atapi_pkt_pkg::PKT_WORDS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        push,
    input  logic [15:0] word,
    output logic [7:0]  opcode,
    output logic        last
);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [IW-1:0] idx_q;

    assign last = push && (idx_q == IW'(WORDS - 1));

    // Word index and opcode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            opcode <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (push) begin
            if (idx_q == '0) opcode <= word[7:0];
            idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/atapi_resp_gen.sv
// Response generator: walks the six data-in words. It computes each word
// from the selected response, lower-numbered byte in bits 7:0.
// Assumes: key/asc are stable during the data-in phase.
module atapi_resp_gen #(
    parameter int WORDS = atapi_pkt_pkg::RESP_WORDS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        pop,
    input  logic        sel_sense,
    input  logic [3:0]  key,
    input  logic [7:0]  asc,
    output logic [15:0] word,
    output logic        last
);
    import atapi_pkt_pkg::*;
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [IW-1:0] ptr_q;
    logic [7:0]    b_lo, b_hi;

    assign b_lo = 8'({ptr_q, 1'b0});
    assign b_hi = 8'({ptr_q, 1'b1});
    assign last = pop && (ptr_q == IW'(WORDS - 1));

    // Assemble the current word from the chosen byte generator.
    always_comb begin
        if (sel_sense) word = {sense_byte(b_hi, key, asc), sense_byte(b_lo, key, asc)};
        else           word = {query_byte(b_hi), query_byte(b_lo)};
    end

    // Word pointer, advanced by each data read.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (clear) ptr_q <= '0;
        else if (pop)   ptr_q <= last ? '0 : ptr_q + 1'b1;
    end
endmodule

// File: rtl/atapi_busy_timer.sv
// Busy timer: once started, raises done in the CYCLES-th cycle.
// Assumes: CYCLES >= 1 and no restart while running.
module atapi_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic          run_q;
    logic [CW-1:0] cnt_q;

    assign done = run_q && (cnt_q == '0);

    // Load on start, count down, stop at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/atapi_pkt_engine.sv
// Packet command engine (top). It holds the task-file registers and the phase
// machine, and decides completion and unit attention.
// Assumes: one host access per cycle; read side effects act at the edge.
module atapi_pkt_engine #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_irq
);
    import atapi_pkt_pkg::*;

    phase_e      ph_q;
    logic [7:0]  err_q, cnt_q, sect_q, bclo_q, bchi_q, dev_q, sasc_q, status;
    logic [3:0]  skey_q;
    logic        errf_q, ua_q;
    logic [7:0]  opcode;
    logic [15:0] resp_word;
    logic        idle, cmd_wr, accept, abort_cmd, pkt_push, pkt_last;
    logic        dat_pop, dat_last, stat_rd, t_done;

    assign idle      = (ph_q == PH_IDLE);
    assign cmd_wr    = host_wr && (host_addr == A_STAT);
    assign accept    = cmd_wr && idle && (host_wdata[7:0] == CMD_PACKET);
    assign abort_cmd = cmd_wr && idle && (host_wdata[7:0] != CMD_PACKET);
    assign pkt_push  = host_wr && (host_addr == A_DATA) && (ph_q == PH_CMD);
    assign dat_pop   = host_rd && (host_addr == A_DATA) && (ph_q == PH_DIN);
    assign stat_rd   = host_rd && (host_addr == A_STAT);

    atapi_pkt_collect #(.WORDS(PKT_WORDS)) u_collect (
        .clk(clk), .rst_n(rst_n), .clear(accept), .push(pkt_push),
        .word(host_wdata), .opcode(opcode), .last(pkt_last)
    );

    atapi_resp_gen #(.WORDS(RESP_WORDS)) u_resp (
        .clk(clk), .rst_n(rst_n), .clear(accept), .pop(dat_pop),
        .sel_sense(opcode == OP_SENSE), .key(skey_q), .asc(sasc_q),
        .word(resp_word), .last(dat_last)
    );

    atapi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(pkt_last || dat_last), .done(t_done)
    );

    // Status byte from the phase and the error flag.
    always_comb begin
        case (ph_q)
            PH_IDLE:         status = {7'b0101000, errf_q};
            PH_CMD, PH_DIN:  status = 8'h58;
            default:         status = 8'hD0;
        endcase
    end

    // Read mux; no side effects here.
    always_comb begin
        case (host_addr)
            A_DATA:        host_rdata = (ph_q == PH_DIN) ? resp_word : 16'hFFFF;
            A_ERR:         host_rdata = {8'h00, err_q};
            A_CNT:         host_rdata = {8'h00, cnt_q};
            A_SECT:        host_rdata = {8'h00, sect_q};
            A_BCLO:        host_rdata = {8'h00, bclo_q};
            A_BCHI:        host_rdata = {8'h00, bchi_q};
            A_DEV:         host_rdata = {8'h00, dev_q};
            A_STAT, A_ALT: host_rdata = {8'h00, status};
            default:       host_rdata = 16'h0000;
        endcase
    end

    // Phase machine, task-file registers, sense record and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE; err_q <= '0; errf_q <= 1'b0; cnt_q <= '0;
            sect_q <= '0; bclo_q <= '0; bchi_q <= '0; dev_q <= '0;
            ua_q <= 1'b1; skey_q <= '0; sasc_q <= '0; host_irq <= 1'b0;
        end else begin
            if (stat_rd) host_irq <= 1'b0;
            if (idle && host_wr) begin
                case (host_addr)
                    A_CNT:   cnt_q  <= host_wdata[7:0];
                    A_SECT:  sect_q <= host_wdata[7:0];
                    A_BCLO:  bclo_q <= host_wdata[7:0];
                    A_BCHI:  bchi_q <= host_wdata[7:0];
                    A_DEV:   dev_q  <= host_wdata[7:0];
                    default: ;
                endcase
            end
            if (accept) begin
                ph_q <= PH_CMD; err_q <= 8'h00; errf_q <= 1'b0;
                cnt_q <= 8'h01; host_irq <= 1'b0;
            end
            if (abort_cmd) begin
                err_q <= 8'h04; errf_q <= 1'b1; host_irq <= 1'b1;
            end
            case (ph_q)
                PH_CMD: if (pkt_last) ph_q <= PH_CBSY;
                PH_CBSY: if (t_done) begin
                    host_irq <= 1'b1;
                    if (ua_q) begin
                        ua_q <= 1'b0; err_q <= 8'h60; errf_q <= 1'b1;
                        cnt_q <= 8'h03; skey_q <= 4'h6; sasc_q <= 8'h29;
                        ph_q <= PH_IDLE;
                    end else if (opcode == OP_READY) begin
                        cnt_q <= 8'h03; skey_q <= '0; sasc_q <= '0;
                        ph_q <= PH_IDLE;
                    end else if (opcode == OP_SENSE || opcode == OP_QUERY) begin
                        cnt_q <= 8'h02; bclo_q <= 8'h0C; bchi_q <= 8'h00;
                        ph_q <= PH_DIN;
                    end else begin
                        err_q <= 8'h04; errf_q <= 1'b1; cnt_q <= 8'h03;
                        skey_q <= 4'h5; sasc_q <= 8'h20; ph_q <= PH_IDLE;
                    end
                end
                PH_DIN: if (dat_last) ph_q <= PH_DBSY;
                PH_DBSY: if (t_done) begin
                    host_irq <= 1'b1; cnt_q <= 8'h03;
                    skey_q <= '0; sasc_q <= '0; ph_q <= PH_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/atapi_pkt_engine_chk.sv
// Checker: temporal properties of the engine, attached by bind below.
// Assumes: the same clock and synchronous reset as the engine.
module atapi_pkt_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ph,
    input logic       irq,
    input logic       t_done,
    input logic       ua,
    input logic [7:0] err,
    input logic [7:0] bclo,
    input logic [7:0] bchi,
    input logic [3:0] addr,
    input logic       wr,
    input logic       rd
);
    import atapi_pkt_pkg::*;

    logic busy;
    assign busy = (ph == PH_CBSY) || (ph == PH_DBSY);

    AST_PKT_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_CMD) |-> !irq); // R2
    AST_BUSY_EXIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && t_done) |=> irq); // R4
    AST_DIN_BCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DIN) |-> (bclo == 8'h0C && bchi == 8'h00)); // R5
    AST_UA_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_CBSY && t_done && ua) |=> (!ua && err == 8'h60)); // R8
    AST_STAT_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_STAT && !wr && !busy) |=> !irq); // R10
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_STAT && busy && !t_done) |=> (ph == $past(ph))); // R11
endmodule

bind atapi_pkt_engine atapi_pkt_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ph(ph_q), .irq(host_irq), .t_done(t_done),
    .ua(ua_q), .err(err_q), .bclo(bclo_q), .bchi(bchi_q),
    .addr(host_addr), .wr(host_wr), .rd(host_rd)
);

// File: tb/atapi_pkt_engine_tb.sv
// Bench: runs directed sequences, then sweeps all 256 packet opcodes. A small
// requirement-level model of unit attention and sense gives the expected values.
module atapi_pkt_engine_tb;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_irq;

    int nchk = 0, nerr = 0;
    bit ua_m = 1'b1;
    logic [3:0] skey_m = '0;
    logic [7:0] sasc_m = '0;

    always #10 clk = ~clk;

    atapi_pkt_engine #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1; host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk); host_addr = a; host_rd = 1'b1; #5; v = host_rdata;
        @(posedge clk); #1; host_rd = 1'b0;
    endtask

    task automatic chk_irq(input string req, input logic exp);
        @(negedge clk); #5; chk(req, {15'd0, host_irq}, {15'd0, exp});
    endtask

    task automatic do_reset;
        rst_n = 1'b0; repeat (3) @(posedge clk); @(negedge clk); rst_n = 1'b1;
        ua_m = 1'b1; skey_m = '0; sasc_m = '0;
    endtask

    function automatic logic [7:0] exp_sense(input int k);
        case (k)
            0: return 8'h70;
            2: return {4'h0, skey_m};
            7: return 8'h0A;
            8: return sasc_m;
            default: return 8'h00;
        endcase
    endfunction

    // Count busy samples, starting from n already taken in the window.
    task automatic busy_window(input int n0, output int n, output logic [15:0] v);
        n = n0; rd(4'd14, v);
        while (v == 16'h00D0 && n < 100) begin n++; rd(4'd14, v); end
    endtask

    task automatic do_packet(input logic [7:0] op, input bit poke);
        logic [15:0] v;
        int n;
        wr(4'd1, 16'h0); wr(4'd2, 16'h0); wr(4'd3, 16'h0);
        wr(4'd4, 16'h8); wr(4'd5, 16'h0); wr(4'd6, 16'h0); wr(4'd7, 16'h00A0);
        rd(4'd14, v); chk("R2 status", v, 16'h58);
        rd(4'd2, v);  chk("R2 count", v, 16'h01);
        rd(4'd4, v);  chk("R2 bcount low kept", v, 16'h08);
        rd(4'd1, v);  chk("R2 error", v, 16'h00);
        chk_irq("R2 irq low", 1'b0);
        for (int i = 0; i < 6; i++) wr(4'd0, (i == 0) ? {8'h00, op} : 16'h0000);
        rd(4'd14, v); chk("R3 busy status", v, 16'hD0);
        n = 1;
        if (poke) begin wr(4'd7, 16'h00EC); wr(4'd4, 16'h0077); n += 2; end
        busy_window(n, n, v);
        chk("R4 busy length", 16'(n), 16'(BUSY));
        chk_irq("R4 irq after busy", 1'b1);
        if (ua_m) begin
            chk("R8 UA status", v, 16'h51);
            rd(4'd1, v); chk("R8 UA error", v, 16'h60);
            rd(4'd2, v); chk("R8 UA count", v, 16'h03);
            ua_m = 1'b0; skey_m = 4'h6; sasc_m = 8'h29;
        end else if (op == 8'h00) begin
            chk("R8 ready status", v, 16'h50);
            rd(4'd1, v); chk("R8 ready error", v, 16'h00);
            rd(4'd2, v); chk("R8 ready count", v, 16'h03);
            skey_m = '0; sasc_m = '0;
        end else if (op == 8'h03 || op == 8'h11) begin
            chk("R5 data status", v, 16'h58);
            rd(4'd2, v); chk("R5 data count", v, 16'h02);
            rd(4'd4, v); chk("R5 bcount low", v, 16'h0C);
            rd(4'd5, v); chk("R5 bcount high", v, 16'h00);
            rd(4'd7, v); chk_irq("R10 status read clears", 1'b0);
            if (poke) begin
                wr(4'd4, 16'h0077); wr(4'd7, 16'h00A0);
                rd(4'd4, v);  chk("R11 bcount write ignored", v, 16'h0C);
                rd(4'd14, v); chk("R11 command ignored", v, 16'h58);
            end
            for (int k = 0; k < 6; k++) begin
                logic [15:0] e;
                if (op == 8'h11) e = {8'(8'h40 + 3 * (2 * k + 1)), 8'(8'h40 + 3 * (2 * k))};
                else             e = {exp_sense(2 * k + 1), exp_sense(2 * k)};
                rd(4'd0, v); chk("R6 response word", v, e);
            end
            rd(4'd2, v); chk("R7 busy count", v, 16'h02);
            busy_window(1, n, v);
            chk("R7 busy length", 16'(n), 16'(BUSY));
            chk("R7 done status", v, 16'h50);
            rd(4'd1, v); chk("R7 done error", v, 16'h00);
            rd(4'd2, v); chk("R7 done count", v, 16'h03);
            chk_irq("R7 irq", 1'b1);
            skey_m = '0; sasc_m = '0;
        end else begin
            chk("R9 unsupported status", v, 16'h51);
            rd(4'd1, v); chk("R9 unsupported error", v, 16'h04);
            rd(4'd2, v); chk("R9 unsupported count", v, 16'h03);
            skey_m = 4'h5; sasc_m = 8'h20;
        end
        if (poke && !(op == 8'h03 || op == 8'h11) ) begin
            rd(4'd4, v); chk("R11 busy write ignored", v, 16'h08);
        end
        rd(4'd14, v); chk_irq("R10 alt read keeps irq", 1'b1);
        rd(4'd7, v);  chk_irq("R10 status read clears irq", 1'b0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        do_reset();
        rd(4'd14, v); chk("R1 reset status", v, 16'h50);
        rd(4'd1, v);  chk("R1 reset error", v, 16'h00);
        rd(4'd2, v);  chk("R1 reset count", v, 16'h00);
        rd(4'd4, v);  chk("R1 reset bcount low", v, 16'h00);
        rd(4'd5, v);  chk("R1 reset bcount high", v, 16'h00);
        rd(4'd0, v);  chk("R1 idle data read", v, 16'hFFFF);
        chk_irq("R1 reset irq", 1'b0);

        wr(4'd7, 16'h00EC);
        rd(4'd14, v); chk("R9 abort status", v, 16'h51);
        rd(4'd1, v);  chk("R9 abort error", v, 16'h04);
        chk_irq("R9 abort irq", 1'b1);
        rd(4'd7, v);  chk_irq("R10 clear after abort", 1'b0);

        do_packet(8'h00, 1'b0);
        do_packet(8'h03, 1'b0);
        do_packet(8'h00, 1'b1);
        do_packet(8'h03, 1'b0);
        do_packet(8'h11, 1'b1);
        do_packet(8'h55, 1'b0);
        do_packet(8'h03, 1'b1);
        for (int op = 0; op < 256; op++) do_packet(8'(op), op[0]);

        do_reset();
        repeat (300) @(posedge clk);
        do_packet(8'h11, 1'b0);
        do_packet(8'h03, 1'b0);
        do_packet(8'h00, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule